// File: doc/BRIEF.md
# Command Fetch Spin Detector

This block sits beside a command-stream parser. It recognises when the stream has parked itself in a wait loop made of a jump whose target is its own location. While the loop stays parked it holds off command fetch. Fetch resumes once the word at the loop address is changed by another agent, or once the get pointer moves away.

The block also keeps an activity state for the fetch unit: running, empty, no-op or spinning. It adds up how many cycles the unit spends outside the running state in a saturating accumulator. When real work resumes after a spin, it keeps fetch held for a fixed number of wake-up cycles.

The parser reports one event per cycle: a method, a no-op, or a jump together with its target and its own location. The block reads the watched word through a combinational read port.

Top module: `spin_detect`

## Requirements
- R1: After a synchronous active-low reset, `act_state` is running, `idle_total` is 0 and `fetch_hold` is low.
- R2: `act_state` encodes running=0, empty=1, no-op=2, spinning=3. `evt_kind` encodes method=0, no-op=1, jump=2, and is only meaningful while `evt_valid` is high.
- R3: A jump event whose target equals its location moves the state to spinning on the next edge. The idle start time is recorded only if the state was running at that moment.
- R4: A self-jump with a nonzero target arms a watch. The word read through `mem_addr`/`mem_data` at the target is captured as the compare value. From then on `fetch_hold` is high while `get_ptr` equals the watch address and `mem_data` equals the compare value. A target of 0 arms no watch.
- R5: If the watched word no longer equals the compare value while `get_ptr` is at the watch address, `fetch_hold` falls at once and the watch is dropped at the next edge.
- R6: Any change of `get_ptr` clears the watch, so a later return to the same address with the same word does not hold fetch.
- R7: From the running state, a no-op event moves the state to no-op. With no event, `get_ptr` equal to `put_ptr` moves it to empty. Both record the idle start time.
- R8: A method event in any non-running state returns the state to running. It adds to `idle_total` the number of clock edges from the edge that recorded the idle start up to and including the method edge.
- R9: A method event that leaves the spinning state holds `fetch_hold` high for `WAKE_CYCLES` cycles after its edge.
- R10: `idle_total` saturates at its all-ones value instead of wrapping.
- R11: A jump event whose target differs from its location leaves the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| get_ptr | input | ADDR_W | Current fetch (get) address |
| put_ptr | input | ADDR_W | Current write (put) address |
| evt_valid | input | 1 | Parser event strobe |
| evt_kind | input | 2 | Event kind: 0 method, 1 no-op, 2 jump |
| jump_target | input | ADDR_W | Target of a jump event |
| jump_loc | input | ADDR_W | Address of the jump command itself |
| mem_addr | output | ADDR_W | Read address for the watched word |
| mem_data | input | DATA_W | Word at `mem_addr`, same cycle |
| fetch_hold | output | 1 | Suppress command fetch |
| act_state | output | 2 | Activity state (R2 encoding) |
| idle_total | output | ACC_W | Saturating idle-cycle accumulator |

## Verification
The hardest situation to reach is an edited loop. The watch is armed and holding, and then the watched word changes while `get_ptr` stays put. The stimulus arms the watch with a self-jump, holds the pointers for a cycle to show the hold persisting, then rewrites the word in the bench's memory model, so the release comes only from the compare. A second sequence moves `get_ptr` away and back with the original word, which separates the clear-on-move path from the compare path. A parallel instance with a 4-bit accumulator receives the same stimulus, so saturation is reached within a few dozen cycles.

// File: rtl/spin_det_pkg.sv
// Shared encodings for the spin detector.
// Assumes: exactly one parser event per cycle at most.
package spin_det_pkg;
    typedef enum logic [1:0] {
        ACT_RUN   = 2'd0,
        ACT_EMPTY = 2'd1,
        ACT_NOP   = 2'd2,
        ACT_SPIN  = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        EVK_METHOD = 2'd0,
        EVK_NOP    = 2'd1,
        EVK_JUMP   = 2'd2
    } evk_e;
endpackage

// File: rtl/spin_watch.sv
// Watch register for a self-jump wait loop: holds the watched address and
// the word captured there, and flags when fetch is still parked on it.
// Assumes: mem_data is a combinational read of mem_addr in the same cycle;
// a watch address of zero means no watch is active.
module spin_watch #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic [ADDR_W-1:0] arm_addr,
    input  logic [ADDR_W-1:0] get_ptr,
    input  logic [DATA_W-1:0] mem_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              spin_match
);
    logic [ADDR_W-1:0] watch_addr_q;
    logic [DATA_W-1:0] cmp_q;
    logic [ADDR_W-1:0] get_last_q;
    logic              active;
    logic              at_watch;

    assign active   = (watch_addr_q != '0);
    assign at_watch = active && (get_ptr == watch_addr_q);
    // Read port points at the new target while arming, else at the watch.
    assign mem_addr = arm ? arm_addr : watch_addr_q;
    assign spin_match = !arm && at_watch && (mem_data == cmp_q);

    // Arm, clear on pointer movement, or clear on an edited word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            watch_addr_q <= '0;
            cmp_q        <= '0;
        end else if (arm) begin
            watch_addr_q <= arm_addr;
            cmp_q        <= mem_data;
        end else if (get_ptr != get_last_q) begin
            watch_addr_q <= '0;
            cmp_q        <= '0;
        end else if (at_watch && (mem_data != cmp_q)) begin
            watch_addr_q <= '0;
            cmp_q        <= '0;
        end
    end

    // Remember the previous get pointer to detect movement.
    always_ff @(posedge clk) begin
        if (!rst_n) get_last_q <= '0;
        else        get_last_q <= get_ptr;
    end
endmodule

// File: rtl/idle_acc.sv
// Idle-time accumulator: a free-running stamp, a start mark, and a
// saturating sum of elapsed stamps when idling ends.
// Assumes: an idle period is shorter than 2**STAMP_W cycles.
module idle_acc #(
    parameter int ACC_W   = 32,
    parameter int STAMP_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mark_start,
    input  logic             add_elapsed,
    output logic [ACC_W-1:0] total
);
    localparam int SUM_W = ((STAMP_W > ACC_W) ? STAMP_W : ACC_W) + 1;
    localparam logic [SUM_W-1:0] CAP = SUM_W'({ACC_W{1'b1}});

    logic [STAMP_W-1:0] stamp_q;
    logic [STAMP_W-1:0] start_q;
    logic [ACC_W-1:0]   total_q;
    logic [STAMP_W-1:0] elapsed;
    logic [SUM_W-1:0]   sum;

    assign elapsed = stamp_q - start_q;
    assign sum     = SUM_W'(total_q) + SUM_W'(elapsed);
    assign total   = total_q;

    // Free-running time base.
    always_ff @(posedge clk) begin
        if (!rst_n) stamp_q <= '0;
        else        stamp_q <= stamp_q + 1'b1;
    end

    // Capture the start of an idle period.
    always_ff @(posedge clk) begin
        if (!rst_n)          start_q <= '0;
        else if (mark_start) start_q <= stamp_q;
    end

    // Saturating accumulation of idle time.
    always_ff @(posedge clk) begin
        if (!rst_n)           total_q <= '0;
        else if (add_elapsed) total_q <= (sum > CAP) ? ACC_W'(CAP) : ACC_W'(sum);
    end
endmodule

// File: rtl/wake_timer.sv
// Down-counter that keeps fetch held for a fixed number of cycles after
// leaving the spinning state.
// Assumes: a new start reloads the full delay.
module wake_timer #(
    parameter int WAKE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(WAKE_CYCLES + 2);

    logic [CNT_W-1:0] cnt_q;

    assign busy = (cnt_q != '0);

    // Load on start, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (start) cnt_q <= CNT_W'(WAKE_CYCLES);
        else if (busy)  cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/spin_detect.sv
// Top of the spin detector: activity-state machine plus watch, idle
// accumulator and wake timer.
// Assumes: the parser raises at most one event per cycle and presents no
// events while fetch_hold is high.
module spin_detect #(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int ACC_W       = 32,
    parameter int WAKE_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] get_ptr,
    input  logic [ADDR_W-1:0] put_ptr,
    input  logic              evt_valid,
    input  logic [1:0]        evt_kind,
    input  logic [ADDR_W-1:0] jump_target,
    input  logic [ADDR_W-1:0] jump_loc,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_data,
    output logic              fetch_hold,
    output logic [1:0]        act_state,
    output logic [ACC_W-1:0]  idle_total
);
    import spin_det_pkg::*;

    localparam int STAMP_W = 32;

    act_e state_q, state_d;
    logic is_method, is_nop, is_jump, self_jump, arm;
    logic spin_match, empty_now, wake_busy;
    logic mark_start, add_elapsed, wake_go;

    assign is_method = evt_valid && (evt_kind == EVK_METHOD);
    assign is_nop    = evt_valid && (evt_kind == EVK_NOP);
    assign is_jump   = evt_valid && (evt_kind == EVK_JUMP);
    assign self_jump = is_jump && (jump_target == jump_loc);
    assign arm       = self_jump && (jump_target != '0);
    assign empty_now = (get_ptr == put_ptr) || spin_match;

    spin_watch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_watch (
        .clk(clk), .rst_n(rst_n), .arm(arm), .arm_addr(jump_target),
        .get_ptr(get_ptr), .mem_data(mem_data), .mem_addr(mem_addr),
        .spin_match(spin_match)
    );

    idle_acc #(.ACC_W(ACC_W), .STAMP_W(STAMP_W)) u_idle (
        .clk(clk), .rst_n(rst_n), .mark_start(mark_start),
        .add_elapsed(add_elapsed), .total(idle_total)
    );

    wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
        .clk(clk), .rst_n(rst_n), .start(wake_go), .busy(wake_busy)
    );

    // Next activity state and the idle/wake side effects of each event.
    always_comb begin
        state_d     = state_q;
        mark_start  = 1'b0;
        add_elapsed = 1'b0;
        wake_go     = 1'b0;
        if (is_method) begin
            if (state_q != ACT_RUN) begin
                add_elapsed = 1'b1;
                wake_go     = (state_q == ACT_SPIN);
            end
            state_d = ACT_RUN;
        end else if (self_jump) begin
            mark_start = (state_q == ACT_RUN);
            state_d    = ACT_SPIN;
        end else if (is_jump) begin
            state_d = state_q;
        end else if (is_nop) begin
            if (state_q == ACT_RUN) begin
                state_d    = ACT_NOP;
                mark_start = 1'b1;
            end
        end else if (empty_now && (state_q == ACT_RUN)) begin
            state_d    = ACT_EMPTY;
            mark_start = 1'b1;
        end
    end

    // Activity state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ACT_RUN;
        else        state_q <= state_d;
    end

    assign act_state  = state_q;
    assign fetch_hold = spin_match || wake_busy;
endmodule

// File: rtl/spin_detect_chk.sv
// Property checker for spin_detect, bound to every instance.
// Assumes: it observes top-level ports only.
module spin_detect_chk #(
    parameter int ACC_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             evt_valid,
    input logic [1:0]       evt_kind,
    input logic             self_eq,
    input logic             fetch_hold,
    input logic [1:0]       act_state,
    input logic [ACC_W-1:0] idle_total
);
    assert_self_jump_spins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_kind == 2'd2 && self_eq) |=> (act_state == 2'd3));

    assert_nop_from_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_kind == 2'd1 && act_state == 2'd0) |=> (act_state == 2'd2));

    assert_method_runs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_kind == 2'd0) |=> (act_state == 2'd0));

    assert_wake_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_kind == 2'd0 && act_state == 2'd3) |=> fetch_hold);

    assert_no_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (idle_total >= $past(idle_total)));

    assert_other_jump_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_kind == 2'd2 && !self_eq) |=> $stable(act_state));
endmodule

bind spin_detect spin_detect_chk #(.ACC_W(ACC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_kind(evt_kind),
    .self_eq(jump_target == jump_loc), .fetch_hold(fetch_hold),
    .act_state(act_state), .idle_total(idle_total)
);

// File: tb/test_spin_detect.sv
`timescale 1ns/1ps
module test_spin_detect;
    localparam int WAKE = 3;
    localparam logic [31:0] WA = 32'hCAFE0001;
    localparam logic [31:0] WB = 32'hCAFE0002;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] get_ptr = 32'h10, put_ptr = 32'h100;
    logic        evt_valid = 1'b0;
    logic [1:0]  evt_kind = 2'd0;
    logic [31:0] jump_target = '0, jump_loc = '0;
    logic [31:0] mem_addr, mem_addr_s, mem_data, mem_data_s;
    logic        fetch_hold, fetch_hold_s;
    logic [1:0]  act_state, act_state_s;
    logic [31:0] idle_total;
    logic [3:0]  idle_small;
    logic [31:0] mem_word [16];

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    assign mem_data   = mem_word[mem_addr[5:2]];
    assign mem_data_s = mem_word[mem_addr_s[5:2]];

    spin_detect #(.ADDR_W(32), .DATA_W(32), .ACC_W(32), .WAKE_CYCLES(WAKE)) i_spin_detect (
        .clk(clk), .rst_n(rst_n), .get_ptr(get_ptr), .put_ptr(put_ptr),
        .evt_valid(evt_valid), .evt_kind(evt_kind), .jump_target(jump_target),
        .jump_loc(jump_loc), .mem_addr(mem_addr), .mem_data(mem_data),
        .fetch_hold(fetch_hold), .act_state(act_state), .idle_total(idle_total)
    );

    spin_detect #(.ADDR_W(32), .DATA_W(32), .ACC_W(4), .WAKE_CYCLES(WAKE)) i_spin_detect_small (
        .clk(clk), .rst_n(rst_n), .get_ptr(get_ptr), .put_ptr(put_ptr),
        .evt_valid(evt_valid), .evt_kind(evt_kind), .jump_target(jump_target),
        .jump_loc(jump_loc), .mem_addr(mem_addr_s), .mem_data(mem_data_s),
        .fetch_hold(fetch_hold_s), .act_state(act_state_s), .idle_total(idle_small)
    );

    typedef struct packed {
        logic        v;
        logic [1:0]  k;
        logic [31:0] tgt;
        logic [31:0] loc;
        logic [31:0] get;
        logic [31:0] put;
        logic [31:0] word;
        logic [1:0]  st;
        logic        hold;
        logic [31:0] idle;
    } row_t;

    // kind: 0 method, 1 nop, 2 jump; state: 0 run, 1 empty, 2 nop, 3 spin
    localparam row_t TBL [13] = '{
        '{1'b0, 2'd0, 32'h0,  32'h0,  32'h10,  32'h100, WA, 2'd0, 1'b0, 32'd0},
        '{1'b1, 2'd0, 32'h0,  32'h0,  32'h14,  32'h100, WA, 2'd0, 1'b0, 32'd0},
        '{1'b1, 2'd1, 32'h0,  32'h0,  32'h14,  32'h100, WA, 2'd2, 1'b0, 32'd0},
        '{1'b1, 2'd0, 32'h0,  32'h0,  32'h18,  32'h100, WA, 2'd0, 1'b0, 32'd1},
        '{1'b1, 2'd2, 32'h40, 32'h40, 32'h40,  32'h100, WA, 2'd3, 1'b1, 32'd1},
        '{1'b0, 2'd0, 32'h0,  32'h0,  32'h40,  32'h100, WA, 2'd3, 1'b1, 32'd1},
        '{1'b0, 2'd0, 32'h0,  32'h0,  32'h40,  32'h100, WB, 2'd3, 1'b0, 32'd1},
        '{1'b1, 2'd0, 32'h0,  32'h0,  32'h44,  32'h100, WB, 2'd0, 1'b1, 32'd4},
        '{1'b0, 2'd0, 32'h0,  32'h0,  32'h44,  32'h100, WB, 2'd0, 1'b1, 32'd4},
        '{1'b0, 2'd0, 32'h0,  32'h0,  32'h44,  32'h100, WB, 2'd0, 1'b1, 32'd4},
        '{1'b0, 2'd0, 32'h0,  32'h0,  32'h44,  32'h100, WB, 2'd0, 1'b0, 32'd4},
        '{1'b0, 2'd0, 32'h0,  32'h0,  32'h100, 32'h100, WB, 2'd1, 1'b0, 32'd4},
        '{1'b1, 2'd0, 32'h0,  32'h0,  32'h104, 32'h100, WB, 2'd0, 1'b0, 32'd5}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Apply one cycle of stimulus; returns at the following falling edge.
    task automatic step(input logic v, input logic [1:0] k, input logic [31:0] tgt,
                        input logic [31:0] loc, input logic [31:0] g, input logic [31:0] p);
        evt_valid = v; evt_kind = k; jump_target = tgt; jump_loc = loc;
        get_ptr = g; put_ptr = p;
        @(posedge clk);
        #1 evt_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mem_word[i] = '0;
        mem_word[0] = WA;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 state", 32'(act_state), 32'd0);
        chk("R1 idle", idle_total, 32'd0);
        chk("R1 hold", 32'(fetch_hold), 32'd0);

        // Table walk covering R2..R9
        for (int r = 0; r < 13; r++) begin
            mem_word[0] = TBL[r].word;
            step(TBL[r].v, TBL[r].k, TBL[r].tgt, TBL[r].loc, TBL[r].get, TBL[r].put);
            chk($sformatf("R2/R3/R4/R5/R7/R8 row%0d state", r), 32'(act_state), 32'(TBL[r].st));
            chk($sformatf("R4/R5/R9 row%0d hold", r), 32'(fetch_hold), 32'(TBL[r].hold));
            chk($sformatf("R8 row%0d idle", r), idle_total, TBL[r].idle);
        end

        // R6: moving get clears the watch
        mem_word[0] = WA;
        step(1, 2'd2, 32'h40, 32'h40, 32'h40, 32'h200);
        chk("R4 armed hold", 32'(fetch_hold), 32'd1);
        step(0, 2'd0, 0, 0, 32'h48, 32'h200);
        chk("R6 moved hold", 32'(fetch_hold), 32'd0);
        step(0, 2'd0, 0, 0, 32'h40, 32'h200);
        chk("R6 returned hold", 32'(fetch_hold), 32'd0);
        step(1, 2'd0, 0, 0, 32'h44, 32'h200);
        chk("R8 idle after spin", idle_total, 32'd8);
        chk("R9 wake hold", 32'(fetch_hold), 32'd1);
        for (int i = 0; i < WAKE; i++) step(0, 2'd0, 0, 0, 32'h44, 32'h200);
        chk("R9 wake over", 32'(fetch_hold), 32'd0);

        // R11: a jump elsewhere leaves the state alone
        step(1, 2'd2, 32'h80, 32'h60, 32'h60, 32'h200);
        chk("R11 state", 32'(act_state), 32'd0);

        // R3 start kept from nop; R4 zero target arms nothing
        step(1, 2'd1, 0, 0, 32'h60, 32'h200);
        step(0, 2'd0, 0, 0, 32'h60, 32'h200);
        step(0, 2'd0, 0, 0, 32'h60, 32'h200);
        step(1, 2'd2, 32'h0, 32'h0, 32'h0, 32'h200);
        chk("R3 spin from nop", 32'(act_state), 32'd3);
        chk("R4 zero target hold", 32'(fetch_hold), 32'd0);
        step(0, 2'd0, 0, 0, 32'h0, 32'h200);
        step(1, 2'd0, 0, 0, 32'h4, 32'h200);
        chk("R3 idle from nop start", idle_total, 32'd13);
        chk("R10 small below cap", 32'(idle_small), 32'd13);
        for (int i = 0; i < WAKE; i++) step(0, 2'd0, 0, 0, 32'h4, 32'h200);

        // R10 saturation
        step(1, 2'd1, 0, 0, 32'h8, 32'h200);
        for (int i = 0; i < 5; i++) step(0, 2'd0, 0, 0, 32'h8, 32'h200);
        step(1, 2'd0, 0, 0, 32'hC, 32'h200);
        chk("R10 wide total", idle_total, 32'd19);
        chk("R10 small saturated", 32'(idle_small), 32'd15);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule